// File: doc/BRIEF.md
# Quadrature Decoder Position Counter

This block turns two clean quadrature phase inputs into a 32-bit signed position count. It also tracks revolutions, compares the position against a programmed value, can wrap the count inside a programmable window, reloads the count on HOME or INDEX marker edges, and watches for a stalled shaft. Events are latched in sticky flags, and each flag has its own interrupt enable.

Software reaches everything through a plain strobe interface: a 4-bit address, separate read and write strobes, 16-bit write data, and combinational read data. Wide values are split into upper and lower 16-bit halves. Reading any live counter copies all counters into hold registers on the same edge, so the upper live half followed by the lower hold half gives one coherent 32-bit position.

Top module: `qdec_poscnt`

## Requirements
- R1: The address map is 0 control, 1 status, 2 interrupt enable, 3 watchdog timeout, 4/5 initial value upper/lower, 6/7 modulus upper/lower, 8/9 compare upper/lower, 10/11 live position upper/lower, 12 live revolution, 13/14 held position upper/lower, 15 held revolution. After reset, control, status, enables, position, revolution and holds read zero, compare reads all ones, and irq and pos_match are low.
- R2: In normal mode each step of {A,B} through 00, 01, 11, 10 and back to 00 adds one to the position, and the reverse order subtracts one. Status bit 7 reads 1 after an up count and 0 after a down count.
- R3: When both phases change in the same sample, no count occurs and status bit 4 (simultaneous change) is set.
- R4: Control bit 4 (reverse) swaps the counting sense in both modes.
- R5: Control bit 5 selects single-phase mode: each rising edge of A counts once, down when B is high and up when B is low. Falling edges of A do not count.
- R6: Control bits 0 and 2 arm HOME and INDEX, and bits 1 and 3 choose the falling edge for them (rising when 0). An armed edge loads the initial value into the position and sets status bit 0 (HOME) or 1 (INDEX). An edge of the other polarity changes neither.
- R7: With control bit 8 clear, an armed INDEX edge steps the revolution count by +1 if the last count was up and by -1 otherwise. With bit 8 set, a modulus roll-over adds one and a roll-under subtracts one.
- R8: With control bit 7 set, an up count from the modulus value goes to the initial value and sets status bit 5. A down count from the initial value goes to the modulus value and sets status bit 6.
- R9: Writing control with bit 10 set loads the initial value into the position. Bit 10 always reads back 0.
- R10: With control bit 9 clear, pos_match is high while the position equals the compare value. Status bit 3 is set on every such equality, whatever the mode. With bit 9 set, pos_match is high for exactly the one cycle after a read of address 10, 11 or 12.
- R11: With control bit 6 set and a nonzero timeout, status bit 2 is set once the timeout count of cycles passes with no phase change. With bit 6 clear it is never set.
- R12: Writing status clears each flag whose data bit is 1. A flag that is set on the same edge as it is cleared stays set.
- R13: irq is high exactly when some status bit 0 to 6 is set and the matching bit of the interrupt enable register is also set.
- R14: A read of address 10, 11 or 12 copies position and revolution into addresses 13 to 15 on that edge. Reads of 13 to 15 do not copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phase_a | input | 1 | Quadrature phase A |
| phase_b | input | 1 | Quadrature phase B |
| home_in | input | 1 | HOME marker input |
| index_in | input | 1 | INDEX marker input |
| bus_addr | input | 4 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from bus_addr |
| pos_match | output | 1 | Position match output |
| irq | output | 1 | Interrupt request |

## Verification
A software clear of a sticky flag can land on the same edge as the hardware event that sets that flag. The bench provokes this by raising HOME one cycle before a write-one-to-clear of the HOME flag. The marker edge detector and the write strobe then act on the same clock edge. It judges the outcome by reading status afterwards: the flag must still be set, and the position must hold the initial value. A second clear on its own must then drop the flag.

// File: rtl/qdec_pkg.sv
package qdec_pkg;

  typedef enum logic [3:0] {
    A_CTL     = 4'd0,
    A_STAT    = 4'd1,
    A_IEN     = 4'd2,
    A_WDT     = 4'd3,
    A_INIT_HI = 4'd4,
    A_INIT_LO = 4'd5,
    A_MOD_HI  = 4'd6,
    A_MOD_LO  = 4'd7,
    A_CMP_HI  = 4'd8,
    A_CMP_LO  = 4'd9,
    A_POS_HI  = 4'd10,
    A_POS_LO  = 4'd11,
    A_REV     = 4'd12,
    A_POSH_HI = 4'd13,
    A_POSH_LO = 4'd14,
    A_REVH    = 4'd15
  } qd_addr_e;

  // control bit positions
  localparam int C_HOME_EN    = 0;
  localparam int C_HOME_FALL  = 1;
  localparam int C_IDX_EN     = 2;
  localparam int C_IDX_FALL   = 3;
  localparam int C_REVERSE    = 4;
  localparam int C_SINGLE     = 5;
  localparam int C_WD_EN      = 6;
  localparam int C_MOD_EN     = 7;
  localparam int C_REV_ON_MOD = 8;
  localparam int C_MATCH_RD   = 9;
  localparam int C_SW_LOAD    = 10;
  localparam int CTL_W        = 10;

  // sticky flag positions
  localparam int F_HOME    = 0;
  localparam int F_IDX     = 1;
  localparam int F_WDOG    = 2;
  localparam int F_CMP     = 3;
  localparam int F_SIMUL   = 4;
  localparam int F_ROLL_OV = 5;
  localparam int F_ROLL_UN = 6;
  localparam int NFLAG     = 7;

  localparam int NTRIG = 2;

  typedef struct packed {
    logic up;
    logic dn;
    logic simul;
    logic moved;
  } qd_step_t;

endpackage

// File: rtl/qdec_phase_decode.sv
module qdec_phase_decode
  import qdec_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     phase_a,
  input  logic     phase_b,
  input  logic     single_mode,
  input  logic     reverse,
  output qd_step_t step
);

  logic [1:0] ab_q, ab_prev;
  logic [1:0] bin_q, bin_p, delta;
  logic       a_rise, raw_up, raw_dn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ab_q    <= 2'b00;
      ab_prev <= 2'b00;
    end else begin
      ab_q    <= {phase_a, phase_b};
      ab_prev <= ab_q;
    end
  end

  always_comb begin
    bin_q  = {ab_q[1], ab_q[1] ^ ab_q[0]};
    bin_p  = {ab_prev[1], ab_prev[1] ^ ab_prev[0]};
    delta  = bin_q - bin_p;
    a_rise = ab_q[1] & ~ab_prev[1] & (delta != 2'd2);
    if (single_mode) begin
      raw_up = a_rise & ~ab_q[0];
      raw_dn = a_rise & ab_q[0];
    end else begin
      raw_up = (delta == 2'd1);
      raw_dn = (delta == 2'd3);
    end
    step.up    = reverse ? raw_dn : raw_up;
    step.dn    = reverse ? raw_up : raw_dn;
    step.simul = (delta == 2'd2);
    step.moved = (ab_q != ab_prev);
  end

  // R3: a two-bit jump never counts, and counts never go both ways
  a_r3_no_count_on_jump: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({step.up, step.dn, step.simul}));

  // R2: any count implies the sampled phases moved since the last sample
  a_r2_count_needs_move: assert property (@(posedge clk) disable iff (!rst_n)
    (step.up || step.dn) |-> step.moved);

endmodule

// File: rtl/qdec_edge_trig.sv
module qdec_edge_trig (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_in,
  input  logic arm,
  input  logic on_fall,
  output logic evt
);

  logic s_q, s_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_q    <= 1'b0;
      s_prev <= 1'b0;
    end else begin
      s_q    <= sig_in;
      s_prev <= s_q;
    end
  end

  always_comb begin
    evt = arm & (on_fall ? (~s_q & s_prev) : (s_q & ~s_prev));
  end

endmodule

// File: rtl/qdec_watchdog.sv
module qdec_watchdog #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic [CW-1:0] timeout,
  input  logic          moved,
  output logic          fire
);

  logic [CW-1:0] cnt_q, cnt_n, cnt_inc;
  logic          idle;

  always_comb begin
    cnt_inc = cnt_q + CW'(1);
    idle    = enable & ~moved & (timeout != '0);
    fire    = idle & (cnt_inc == timeout);
    if (!idle || fire) cnt_n = '0;
    else               cnt_n = cnt_inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  // R11: a phase change always restarts the idle window
  a_r11_move_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    moved |=> (cnt_q == '0));

endmodule

// File: rtl/qdec_poscnt.sv
module qdec_poscnt
  import qdec_pkg::*;
#(
  parameter int DW    = 16,
  parameter int REV_W = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          phase_a,
  input  logic          phase_b,
  input  logic          home_in,
  input  logic          index_in,
  input  logic [3:0]    bus_addr,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          pos_match,
  output logic          irq
);

  localparam int PW = 2 * DW;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rs_q;
  logic       rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i = rs_q[1];

  // state
  logic [CTL_W-1:0] ctl_q, ctl_n;
  logic [NFLAG-1:0] ien_q, ien_n, flags_q, flags_n, flag_set, flag_clr;
  logic [DW-1:0]    wdt_q, wdt_n;
  logic [PW-1:0]    init_q, init_n, mod_q, mod_n, cmp_q, cmp_n;
  logic [PW-1:0]    pos_q, pos_n, posh_q, posh_n;
  logic [REV_W-1:0] rev_q, rev_n, revh_q, revh_n;
  logic             dir_q, dir_n, rdm_q, rdm_n;

  qd_step_t         step;
  logic [NTRIG-1:0] trig_sig, trig_arm, trig_fall, trig_evt;
  logic             home_evt, idx_evt, wd_fire;
  logic             sw_load, load, rd_cnt, cmp_eq, roll_ov, roll_un;

  qdec_phase_decode u_dec (
    .clk         (clk),
    .rst_n       (rst_i),
    .phase_a     (phase_a),
    .phase_b     (phase_b),
    .single_mode (ctl_q[C_SINGLE]),
    .reverse     (ctl_q[C_REVERSE]),
    .step        (step)
  );

  assign trig_sig  = {index_in, home_in};
  assign trig_arm  = {ctl_q[C_IDX_EN], ctl_q[C_HOME_EN]};
  assign trig_fall = {ctl_q[C_IDX_FALL], ctl_q[C_HOME_FALL]};

  for (genvar gi = 0; gi < NTRIG; gi++) begin : g_trig
    qdec_edge_trig u_trig (
      .clk     (clk),
      .rst_n   (rst_i),
      .sig_in  (trig_sig[gi]),
      .arm     (trig_arm[gi]),
      .on_fall (trig_fall[gi]),
      .evt     (trig_evt[gi])
    );
  end

  assign home_evt = trig_evt[0];
  assign idx_evt  = trig_evt[1];

  qdec_watchdog #(.CW(DW)) u_wdog (
    .clk     (clk),
    .rst_n   (rst_i),
    .enable  (ctl_q[C_WD_EN]),
    .timeout (wdt_q),
    .moved   (step.moved),
    .fire    (wd_fire)
  );

  // configuration writes
  always_comb begin
    ctl_n  = ctl_q;
    ien_n  = ien_q;
    wdt_n  = wdt_q;
    init_n = init_q;
    mod_n  = mod_q;
    cmp_n  = cmp_q;
    if (bus_wr) begin
      case (bus_addr)
        A_CTL:     ctl_n          = bus_wdata[CTL_W-1:0];
        A_IEN:     ien_n          = bus_wdata[NFLAG-1:0];
        A_WDT:     wdt_n          = bus_wdata;
        A_INIT_HI: init_n[PW-1:DW] = bus_wdata;
        A_INIT_LO: init_n[DW-1:0]  = bus_wdata;
        A_MOD_HI:  mod_n[PW-1:DW]  = bus_wdata;
        A_MOD_LO:  mod_n[DW-1:0]   = bus_wdata;
        A_CMP_HI:  cmp_n[PW-1:DW]  = bus_wdata;
        A_CMP_LO:  cmp_n[DW-1:0]   = bus_wdata;
        default: ;
      endcase
    end
  end

  // counting, wrap, revolution
  always_comb begin
    sw_load = bus_wr && (bus_addr == A_CTL) && bus_wdata[C_SW_LOAD];
    load    = sw_load | home_evt | idx_evt;
    rd_cnt  = bus_rd && ((bus_addr == A_POS_HI) || (bus_addr == A_POS_LO) ||
                         (bus_addr == A_REV));
    roll_ov = 1'b0;
    roll_un = 1'b0;
    pos_n   = pos_q;
    dir_n   = dir_q;

    if (load) begin
      pos_n = init_q;
    end else if (step.up) begin
      if (ctl_q[C_MOD_EN] && (pos_q == mod_q)) begin
        pos_n   = init_q;
        roll_ov = 1'b1;
      end else begin
        pos_n = pos_q + PW'(1);
      end
    end else if (step.dn) begin
      if (ctl_q[C_MOD_EN] && (pos_q == init_q)) begin
        pos_n   = mod_q;
        roll_un = 1'b1;
      end else begin
        pos_n = pos_q - PW'(1);
      end
    end
    if (step.up)      dir_n = 1'b1;
    else if (step.dn) dir_n = 1'b0;

    rev_n = rev_q;
    if (ctl_q[C_REV_ON_MOD]) begin
      if (roll_ov)      rev_n = rev_q + REV_W'(1);
      else if (roll_un) rev_n = rev_q - REV_W'(1);
    end else if (idx_evt) begin
      rev_n = dir_q ? rev_q + REV_W'(1) : rev_q - REV_W'(1);
    end

    posh_n = rd_cnt ? pos_q : posh_q;
    revh_n = rd_cnt ? rev_q : revh_q;
    rdm_n  = rd_cnt;
  end

  // sticky flags
  always_comb begin
    cmp_eq = (pos_q == cmp_q);
    flag_set = '0;
    flag_set[F_HOME]    = home_evt;
    flag_set[F_IDX]     = idx_evt;
    flag_set[F_WDOG]    = wd_fire;
    flag_set[F_CMP]     = cmp_eq;
    flag_set[F_SIMUL]   = step.simul;
    flag_set[F_ROLL_OV] = roll_ov;
    flag_set[F_ROLL_UN] = roll_un;
    flag_clr = (bus_wr && (bus_addr == A_STAT)) ? bus_wdata[NFLAG-1:0] : '0;
    flags_n  = (flags_q & ~flag_clr) | flag_set;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      ctl_q   <= '0;
      ien_q   <= '0;
      wdt_q   <= '0;
      init_q  <= '0;
      mod_q   <= '0;
      cmp_q   <= '1;
      pos_q   <= '0;
      posh_q  <= '0;
      rev_q   <= '0;
      revh_q  <= '0;
      flags_q <= '0;
      dir_q   <= 1'b0;
      rdm_q   <= 1'b0;
    end else begin
      ctl_q   <= ctl_n;
      ien_q   <= ien_n;
      wdt_q   <= wdt_n;
      init_q  <= init_n;
      mod_q   <= mod_n;
      cmp_q   <= cmp_n;
      pos_q   <= pos_n;
      posh_q  <= posh_n;
      rev_q   <= rev_n;
      revh_q  <= revh_n;
      flags_q <= flags_n;
      dir_q   <= dir_n;
      rdm_q   <= rdm_n;
    end
  end

  // outputs
  always_comb begin
    pos_match = ctl_q[C_MATCH_RD] ? rdm_q : cmp_eq;
    irq       = |(flags_q & ien_q);
    case (bus_addr)
      A_CTL:     bus_rdata = DW'(ctl_q);
      A_STAT:    bus_rdata = DW'({dir_q, flags_q});
      A_IEN:     bus_rdata = DW'(ien_q);
      A_WDT:     bus_rdata = wdt_q;
      A_INIT_HI: bus_rdata = init_q[PW-1:DW];
      A_INIT_LO: bus_rdata = init_q[DW-1:0];
      A_MOD_HI:  bus_rdata = mod_q[PW-1:DW];
      A_MOD_LO:  bus_rdata = mod_q[DW-1:0];
      A_CMP_HI:  bus_rdata = cmp_q[PW-1:DW];
      A_CMP_LO:  bus_rdata = cmp_q[DW-1:0];
      A_POS_HI:  bus_rdata = pos_q[PW-1:DW];
      A_POS_LO:  bus_rdata = pos_q[DW-1:0];
      A_REV:     bus_rdata = DW'(rev_q);
      A_POSH_HI: bus_rdata = posh_q[PW-1:DW];
      A_POSH_LO: bus_rdata = posh_q[DW-1:0];
      A_REVH:    bus_rdata = DW'(revh_q);
      default:   bus_rdata = '0;
    endcase
  end

  // R9: a software load command places the initial value on the next edge
  a_r9_sw_load: assert property (@(posedge clk) disable iff (!rst_i)
    sw_load |=> (pos_q == $past(init_q)));

  // R12: an event always leaves its flag set, even against a clear
  a_r12_set_wins: assert property (@(posedge clk) disable iff (!rst_i)
    (|flag_set) |=> ((flags_q & $past(flag_set)) == $past(flag_set)));

  // R14: a counter read freezes the position into the hold register
  a_r14_hold_capture: assert property (@(posedge clk) disable iff (!rst_i)
    rd_cnt |=> (posh_q == $past(pos_q)));

  // R8: upward crossing of the modulus lands on the initial value
  a_r8_wrap_up: assert property (@(posedge clk) disable iff (!rst_i)
    (ctl_q[C_MOD_EN] && step.up && !load && (pos_q == mod_q)) |=>
      (pos_q == $past(init_q)));

  // R11: the watchdog timeout raises its flag
  a_r11_wdog_flag: assert property (@(posedge clk) disable iff (!rst_i)
    wd_fire |=> flags_q[F_WDOG]);

  // R10: in read-match mode the output only follows a counter read
  a_r10_match_on_read: assert property (@(posedge clk) disable iff (!rst_i)
    (ctl_q[C_MATCH_RD] && pos_match) |-> $past(rd_cnt));

endmodule

// File: tb/qdec_poscnt_tb_top.sv
module qdec_poscnt_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        phase_a, phase_b, home_in, index_in;
  logic [3:0]  bus_addr;
  logic        bus_wr, bus_rd;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic        pos_match, irq;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  logic [1:0]  ph;
  logic [31:0] exp_pos;
  logic [15:0] exp_rev;
  logic [15:0] rv, hi, lo;
  logic [31:0] pv;

  always #2 clk = ~clk;

  qdec_poscnt dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .phase_a   (phase_a),
    .phase_b   (phase_b),
    .home_in   (home_in),
    .index_in  (index_in),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pos_match (pos_match),
    .irq       (irq)
  );

  function automatic logic [1:0] gray(input logic [1:0] p);
    case (p)
      2'd0:    return 2'b00;
      2'd1:    return 2'b01;
      2'd2:    return 2'b11;
      default: return 2'b10;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic rd_pos(output logic [31:0] p);
    logic [15:0] h, l;
    rd(4'd10, h);
    rd(4'd14, l);
    p = {h, l};
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic quad(input bit up);
    @(negedge clk);
    ph = up ? ph + 2'd1 : ph - 2'd1;
    {phase_a, phase_b} = gray(ph);
    settle();
  endtask

  task automatic drive_ab(input logic [1:0] v);
    @(negedge clk);
    {phase_a, phase_b} = v;
    settle();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; phase_a = 1'b0; phase_b = 1'b0; home_in = 1'b0; index_in = 1'b0;
    bus_addr = 4'd0; bus_wr = 1'b0; bus_rd = 1'b0; bus_wdata = 16'd0;
    ph = 2'd0; exp_pos = 32'd0; exp_rev = 16'd0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(4'd0, rv);  check("R1 ctl", {16'd0, rv}, 32'd0);
    rd(4'd1, rv);  check("R1 stat", {16'd0, rv}, 32'd0);
    rd(4'd8, rv);  check("R1 cmp_hi", {16'd0, rv}, 32'h0000_FFFF);
    rd(4'd9, rv);  check("R1 cmp_lo", {16'd0, rv}, 32'h0000_FFFF);
    rd_pos(pv);    check("R1 pos", pv, 32'd0);
    check("R1 irq/match", {30'd0, irq, pos_match}, 32'd0);

    // R5 single-phase counting
    wr(4'd0, 16'h0020);
    drive_ab(2'b10); drive_ab(2'b00);
    drive_ab(2'b10); drive_ab(2'b00);
    drive_ab(2'b10); drive_ab(2'b00);
    drive_ab(2'b01); drive_ab(2'b11); drive_ab(2'b01);
    drive_ab(2'b11); drive_ab(2'b01); drive_ab(2'b00);
    rd_pos(pv);    check("R5 single phase", pv, 32'd1);
    rd(4'd1, rv);  check("R2 dir after down", {31'd0, rv[7]}, 32'd0);

    // R2 random walk in 4x mode
    wr(4'd0, 16'h0000);
    exp_pos = 32'd1;
    for (int i = 1; i <= 300; i++) begin
      bit up;
      up = $urandom_range(1, 0) == 1;
      if ($urandom_range(7, 0) == 0) settle();
      quad(up);
      exp_pos = up ? exp_pos + 32'd1 : exp_pos - 32'd1;
      if (i % 50 == 0) begin
        rd_pos(pv); check("R2 random walk", pv, exp_pos);
      end
    end
    quad(1'b1); exp_pos = exp_pos + 32'd1;
    rd(4'd1, rv);  check("R2 dir after up", {31'd0, rv[7]}, 32'd1);

    // R4 reverse sense
    wr(4'd0, 16'h0010);
    for (int i = 0; i < 5; i++) quad(1'b1);
    exp_pos = exp_pos - 32'd5;
    rd_pos(pv);    check("R4 reverse", pv, exp_pos);
    wr(4'd0, 16'h0000);

    // R3 illegal jump
    wr(4'd1, 16'h007F);
    @(negedge clk);
    ph = ph + 2'd2;
    {phase_a, phase_b} = gray(ph);
    settle();
    rd_pos(pv);    check("R3 no count on jump", pv, exp_pos);
    rd(4'd1, rv);  check("R3 simul flag", {31'd0, rv[4]}, 32'd1);
    wr(4'd1, 16'h0010);
    rd(4'd1, rv);  check("R12 w1c simul", {31'd0, rv[4]}, 32'd0);

    // R9 software load
    wr(4'd4, 16'h0001); wr(4'd5, 16'h2345);
    wr(4'd0, 16'h0400);
    exp_pos = 32'h0001_2345;
    rd_pos(pv);    check("R9 sw load", pv, exp_pos);
    rd(4'd0, rv);  check("R9 self clear", {16'd0, rv}, 32'd0);

    // R6 / R12 HOME edge against same-edge clear
    wr(4'd0, 16'h0001);
    wr(4'd1, 16'h007F);
    quad(1'b1); quad(1'b1);
    @(negedge clk);
    home_in = 1'b1;
    wr(4'd1, 16'h0001);
    settle();
    rd_pos(pv);    check("R6 home load", pv, exp_pos);
    rd(4'd1, rv);  check("R12 set wins over clear", {31'd0, rv[0]}, 32'd1);
    wr(4'd1, 16'h0001);
    rd(4'd1, rv);  check("R12 clear", {31'd0, rv[0]}, 32'd0);
    quad(1'b1); exp_pos = exp_pos + 32'd1;
    @(negedge clk); home_in = 1'b0; settle();
    rd_pos(pv);    check("R6 unarmed edge pos", pv, exp_pos);
    rd(4'd1, rv);  check("R6 unarmed edge flag", {31'd0, rv[0]}, 32'd0);

    // R6 / R7 INDEX falling edge
    wr(4'd0, 16'h000C);
    @(negedge clk); index_in = 1'b1; settle();
    rd_pos(pv);    check("R6 index rising ignored", pv, exp_pos);
    @(negedge clk); index_in = 1'b0; settle();
    exp_pos = 32'h0001_2345; exp_rev = exp_rev + 16'd1;
    rd_pos(pv);    check("R6 index load", pv, exp_pos);
    rd(4'd1, rv);  check("R6 index flag", {31'd0, rv[1]}, 32'd1);
    rd(4'd12, rv); check("R7 rev on index", {16'd0, rv}, {16'd0, exp_rev});

    // R8 / R7 modulo window
    wr(4'd1, 16'h007F);
    wr(4'd4, 16'h0000); wr(4'd5, 16'h0002);
    wr(4'd6, 16'h0000); wr(4'd7, 16'h0005);
    wr(4'd0, 16'h0580);
    quad(1'b1); quad(1'b1); quad(1'b1);
    rd_pos(pv);    check("R8 reach modulus", pv, 32'd5);
    quad(1'b1); exp_rev = exp_rev + 16'd1;
    rd_pos(pv);    check("R8 roll over", pv, 32'd2);
    rd(4'd1, rv);  check("R8 roll over flag", {31'd0, rv[5]}, 32'd1);
    rd(4'd12, rv); check("R7 rev on roll over", {16'd0, rv}, {16'd0, exp_rev});
    quad(1'b0); exp_rev = exp_rev - 16'd1;
    rd_pos(pv);    check("R8 roll under", pv, 32'd5);
    rd(4'd1, rv);  check("R8 roll under flag", {31'd0, rv[6]}, 32'd1);
    rd(4'd12, rv); check("R7 rev on roll under", {16'd0, rv}, {16'd0, exp_rev});

    // R10 compare
    wr(4'd0, 16'h0000);
    wr(4'd8, 16'h0000); wr(4'd9, 16'h0006);
    @(negedge clk);
    check("R10 no match", {31'd0, pos_match}, 32'd0);
    quad(1'b1);
    check("R10 match", {31'd0, pos_match}, 32'd1);
    rd(4'd1, rv);  check("R10 cmp flag", {31'd0, rv[3]}, 32'd1);
    wr(4'd0, 16'h0200);
    check("R10 read mode idle", {31'd0, pos_match}, 32'd0);
    rd(4'd12, rv);
    check("R10 read pulse", {31'd0, pos_match}, 32'd1);
    @(negedge clk);
    check("R10 read pulse ends", {31'd0, pos_match}, 32'd0);
    wr(4'd0, 16'h0000);
    quad(1'b1); exp_pos = 32'd7;

    // R13 interrupt
    wr(4'd2, 16'h0000);
    @(negedge clk);
    check("R13 masked", {31'd0, irq}, 32'd0);
    wr(4'd2, 16'h0008);
    check("R13 enabled", {31'd0, irq}, 32'd1);
    wr(4'd1, 16'h007F);
    check("R13 cleared", {31'd0, irq}, 32'd0);

    // R11 watchdog
    wr(4'd3, 16'd20);
    wr(4'd0, 16'h0040);
    repeat (8) @(negedge clk);
    rd(4'd1, rv);  check("R11 before timeout", {31'd0, rv[2]}, 32'd0);
    repeat (30) @(negedge clk);
    rd(4'd1, rv);  check("R11 timeout", {31'd0, rv[2]}, 32'd1);
    wr(4'd0, 16'h0000);
    wr(4'd1, 16'h007F);
    repeat (60) @(negedge clk);
    rd(4'd1, rv);  check("R11 disabled", {31'd0, rv[2]}, 32'd0);

    // R14 snapshot coherence
    rd(4'd10, hi);
    quad(1'b1);
    rd(4'd14, lo);
    check("R14 held value", {hi, lo}, exp_pos);
    rd(4'd13, rv); check("R14 held upper", {16'd0, rv}, {16'd0, exp_pos[31:16]});
    exp_pos = exp_pos + 32'd1;
    rd_pos(pv);    check("R14 fresh value", pv, exp_pos);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule